// File: doc/BRIEF.md
# Two-Wire Register Slave with Block Write and Write-History Readback

This block is the slave end of a two-wire serial control bus. It watches the SCL and SDA lines and pulls SDA low through an open-drain enable when it must acknowledge or send a zero. After a matching write address, the first byte it receives is a subaddress. The bytes that follow become register write strobes, each carrying the subaddress, a byte index and the data byte. Multi-byte registers, such as mixer gains or control words, therefore take several strobes at one subaddress.

The top bit of the subaddress selects the mode. When that bit is clear, the transfer is a plain write: every data byte is accepted. When it is set, the transfer is a block write: the next byte is a length of 1 to 32, and only that many data bytes are accepted. The read path does not return register contents. It returns the last subaddress received, followed by the six most recent data bytes written. This lets a host confirm what it sent.

An external strap pin supplies the lowest bit of the 7-bit address. Both bus lines are synchronised and filtered for glitches before any edge is detected. Standard-mode timing is assumed, and the slave never stretches the clock.

Top module: `i2c_reg_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal binary 011010 followed by `addr_sel_i`. Bit 0 of the address byte is the direction: 0 means write and 1 means read. On a mismatch the slave never drives SDA until the next Start.
- R2: The slave changes `sda_oe_o` only while SCL is low.
- R3: After a matching write address, the first byte is the subaddress, and the slave acknowledges it. If bit 7 of the subaddress is 0, every later byte is acknowledged and produces a write strobe. The strobe carries `wr_addr_o` = subaddress bits 6:0 with bit 7 forced to 0, `wr_idx_o` = the byte's position counted from 0, and `wr_data_o` = the byte.
- R4: If bit 7 of the subaddress is 1 (block mode), the byte after the subaddress is a length. The slave acknowledges it only when its value is 1 to 32, and the length byte itself is never written.
- R5: In block mode, a data byte beyond the length is not acknowledged and not written. A length of 0 or above 32 is not acknowledged. In either case the rest of the transfer is ignored.
- R6: `wr_en_o` is high for exactly one clock per accepted byte. It rises while SCL is low, in the same cycle that the slave starts driving that byte's acknowledge.
- R7: A read returns the last subaddress received (all 8 bits), then the last six data bytes written, oldest first. After the seventh byte it wraps back to the subaddress. Bytes are sent MSB first.
- R8: If the master acknowledges a read byte, the slave goes on driving the next byte. If the master does not acknowledge it, the slave releases SDA and ignores the bus until the next Start.
- R9: A Stop or a repeated Start at any point discards a partially received byte, and no write happens for that byte. A repeated Start begins a new address phase.
- R10: A low or high pulse on SCL or SDA that lasts one clock is ignored.
- R11: After reset, SDA is released and no strobe is issued. The held subaddress and all six history bytes read back as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel_i | input | 1 | Strap value for address bit 0 |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 8 | Register subaddress for the strobe |
| wr_idx_o | output | 6 | Byte position within the transfer |
| wr_data_o | output | 8 | Data byte for the strobe |

## Verification
The slave is driven with plain writes of several lengths under both strap values, and with writes to the strapped-off address; these separate address decoding from data handling. Block writes with an exact length, an overrun byte, a zero length and an oversized length distinguish how the acknowledge is gated from how strobes are issued. Readbacks before and after writes, including reads long enough to wrap, test the ordering of the history. A Stop and a repeated Start part-way through a byte, and one-clock glitches on both lines during a write, show whether partial bits or noise ever reach a strobe.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_CNT,
        ST_CNT_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } slv_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CNT_W-1:0]       cnt;
        logic                   level;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.sync = {flt_q.sync[SYNC_STAGES-2:0], line_i};
        if (flt_q.sync[SYNC_STAGES-1] != flt_q.level) begin
            if (flt_q.cnt == CNT_W'(FILT_LEN - 1)) begin
                flt_d.level = flt_q.sync[SYNC_STAGES-1];
                flt_d.cnt   = '0;
            end else begin
                flt_d.cnt = flt_q.cnt + 1'b1;
            end
        end else begin
            flt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q.sync  <= '1;
            flt_q.cnt   <= '0;
            flt_q.level <= 1'b1;
        end else begin
            flt_q <= flt_d;
        end
    end

    assign line_o = flt_q.level;
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_i;
        prev_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    assign scl_rise_o = scl_i & ~prev_q.scl;
    assign scl_fall_o = ~scl_i & prev_q.scl;
    assign start_o    = scl_i & prev_q.scl & prev_q.sda & ~sda_i;
    assign stop_o     = scl_i & prev_q.scl & ~prev_q.sda & sda_i;
endmodule

// File: rtl/i2c_wr_history.sv
module i2c_wr_history
    import i2c_slv_pkg::*;
#(
    parameter int DEPTH  = 6,
    parameter int RIDX_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  byte_t             push_data_i,
    input  byte_t             sub_i,
    input  logic [RIDX_W-1:0] rd_idx_i,
    output byte_t             rd_byte_o
);
    logic [DEPTH-1:0][BYTE_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (push_i) begin
            for (int k = 0; k < DEPTH - 1; k++) mem_d[k] = mem_q[k+1];
            mem_d[DEPTH-1] = push_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    always_comb begin
        rd_byte_o = sub_i;
        for (int k = 0; k < DEPTH; k++) begin
            if (rd_idx_i == RIDX_W'(k + 1)) rd_byte_o = mem_q[k];
        end
    end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_slv_pkg::*;
#(
    parameter logic [5:0] ADDR_HI     = 6'b011010,
    parameter int         HIST_DEPTH  = 6,
    parameter int         MAX_BLK     = 32,
    parameter int         IDX_W       = 6,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_sel_i,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    output logic             wr_en_o,
    output logic [7:0]       wr_addr_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [7:0]       wr_data_o
);
    localparam int CNT_W  = $clog2(MAX_BLK + 1);
    localparam int RIDX_W = $clog2(HIST_DEPTH + 1);

    typedef struct packed {
        slv_state_e        state;
        byte_t             shreg;
        logic [3:0]        bitcnt;
        logic              sda_oe;
        logic              rw;
        byte_t             sub;
        logic              blk;
        logic [CNT_W-1:0]  left;
        logic [IDX_W-1:0]  idx;
        logic [RIDX_W-1:0] ridx;
        logic              wr_en;
        byte_t             wr_data;
        logic [IDX_W-1:0]  wr_idx;
    } slv_regs_t;

    slv_regs_t r_d, r_q;

    logic  scl_f, sda_f;
    logic  ev_rise, ev_fall, ev_start, ev_stop;
    byte_t rb_byte;
    logic  load_tx;

    logic [1:0] line_raw, line_flt;
    assign line_raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        i2c_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(line_raw[g]),
            .line_o(line_flt[g])
        );
    end

    assign scl_f = line_flt[1];
    assign sda_f = line_flt[0];

    i2c_bus_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_f),
        .sda_i     (sda_f),
        .scl_rise_o(ev_rise),
        .scl_fall_o(ev_fall),
        .start_o   (ev_start),
        .stop_o    (ev_stop)
    );

    i2c_wr_history #(
        .DEPTH (HIST_DEPTH),
        .RIDX_W(RIDX_W)
    ) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (r_q.wr_en),
        .push_data_i(r_q.wr_data),
        .sub_i      (r_q.sub),
        .rd_idx_i   (r_q.ridx),
        .rd_byte_o  (rb_byte)
    );

    always_comb begin
        r_d       = r_q;
        r_d.wr_en = 1'b0;
        load_tx   = 1'b0;

        if (ev_start) begin
            r_d.state  = ST_ADDR;
            r_d.bitcnt = '0;
            r_d.sda_oe = 1'b0;
            r_d.ridx   = '0;
        end else if (ev_stop) begin
            r_d.state  = ST_IDLE;
            r_d.bitcnt = '0;
            r_d.sda_oe = 1'b0;
        end else begin
            case (r_q.state)
                ST_ADDR, ST_SUB, ST_CNT, ST_WDATA: begin
                    if (ev_rise) begin
                        r_d.shreg  = {r_q.shreg[BYTE_W-2:0], sda_f};
                        r_d.bitcnt = r_q.bitcnt + 4'd1;
                    end else if (ev_fall && r_q.bitcnt == 4'd8) begin
                        r_d.bitcnt = '0;
                        case (r_q.state)
                            ST_ADDR: begin
                                if (r_q.shreg[7:1] == {ADDR_HI, addr_sel_i}) begin
                                    r_d.rw     = r_q.shreg[0];
                                    r_d.sda_oe = 1'b1;
                                    r_d.state  = ST_ADDR_ACK;
                                end else begin
                                    r_d.state = ST_IGNORE;
                                end
                            end
                            ST_SUB: begin
                                r_d.sub    = r_q.shreg;
                                r_d.blk    = r_q.shreg[7];
                                r_d.idx    = '0;
                                r_d.sda_oe = 1'b1;
                                r_d.state  = ST_SUB_ACK;
                            end
                            ST_CNT: begin
                                if (r_q.shreg != '0 && r_q.shreg <= BYTE_W'(MAX_BLK)) begin
                                    r_d.left   = CNT_W'(r_q.shreg);
                                    r_d.sda_oe = 1'b1;
                                    r_d.state  = ST_CNT_ACK;
                                end else begin
                                    r_d.state = ST_IGNORE;
                                end
                            end
                            default: begin
                                if (r_q.blk && r_q.left == '0) begin
                                    r_d.state = ST_IGNORE;
                                end else begin
                                    r_d.wr_en   = 1'b1;
                                    r_d.wr_data = r_q.shreg;
                                    r_d.wr_idx  = r_q.idx;
                                    r_d.idx     = r_q.idx + 1'b1;
                                    if (r_q.blk) r_d.left = r_q.left - 1'b1;
                                    r_d.sda_oe  = 1'b1;
                                    r_d.state   = ST_WDATA_ACK;
                                end
                            end
                        endcase
                    end
                end

                ST_ADDR_ACK, ST_SUB_ACK, ST_CNT_ACK, ST_WDATA_ACK: begin
                    if (ev_fall) begin
                        r_d.sda_oe = 1'b0;
                        r_d.bitcnt = '0;
                        case (r_q.state)
                            ST_ADDR_ACK: begin
                                if (r_q.rw) load_tx = 1'b1;
                                else        r_d.state = ST_SUB;
                            end
                            ST_SUB_ACK: r_d.state = r_q.blk ? ST_CNT : ST_WDATA;
                            default:    r_d.state = ST_WDATA;
                        endcase
                    end
                end

                ST_RDATA: begin
                    if (ev_fall) begin
                        if (r_q.bitcnt == 4'd8) begin
                            r_d.sda_oe = 1'b0;
                            r_d.bitcnt = '0;
                            r_d.state  = ST_RDATA_ACK;
                        end else begin
                            r_d.sda_oe = ~r_q.shreg[BYTE_W-1];
                            r_d.shreg  = {r_q.shreg[BYTE_W-2:0], 1'b0};
                            r_d.bitcnt = r_q.bitcnt + 4'd1;
                        end
                    end
                end

                ST_RDATA_ACK: begin
                    if (ev_rise && sda_f) r_d.state = ST_IGNORE;
                    else if (ev_fall)     load_tx = 1'b1;
                end

                default: ;
            endcase
        end

        if (load_tx) begin
            r_d.shreg  = {rb_byte[BYTE_W-2:0], 1'b0};
            r_d.sda_oe = ~rb_byte[BYTE_W-1];
            r_d.bitcnt = 4'd1;
            r_d.ridx   = (r_q.ridx == RIDX_W'(HIST_DEPTH)) ? '0 : r_q.ridx + 1'b1;
            r_d.state  = ST_RDATA;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o  = r_q.sda_oe;
    assign wr_en_o   = r_q.wr_en;
    assign wr_addr_o = {1'b0, r_q.sub[6:0]};
    assign wr_idx_o  = r_q.wr_idx;
    assign wr_data_o = r_q.wr_data;
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe_o,
    input logic wr_en_o
);
    // R2: the slave's SDA drive only moves while the clock line is low
    a_r2_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    // R6: a strobe lasts one cycle
    a_r6_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);

    // R6: a strobe coincides with the acknowledge drive
    a_r6_strobe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> sda_oe_o);

    // R6: a strobe is issued while SCL is low
    a_r6_strobe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> !scl_i);
endmodule

bind i2c_reg_slave i2c_reg_slave_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_oe_o(sda_oe_o),
    .wr_en_o (wr_en_o)
);

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
    localparam int Q = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
    logic sda_oe, wr_en, sda_line;
    logic [7:0] wr_addr, wr_data;
    logic [5:0] wr_idx;

    assign sda_line = sda_m & ~sda_oe;

    i2c_reg_slave i_i2c_reg_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_sel_i(addr_sel),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe_o  (sda_oe),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data)
    );

    int n_tests = 0, n_fail = 0;
    logic [31:0] exp_wr[$];
    logic [7:0]  hist[6];
    logic [7:0]  last_sub = 8'h00;
    logic        glitch_en = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    // every-clock comparison of the strobe against the model queue
    always @(negedge clk) begin
        logic [31:0] e, a;
        if (rst_n && wr_en) begin
            a = {8'h00, wr_addr, 2'b00, wr_idx, wr_data};
            if (exp_wr.size() == 0) begin
                check(1'b0, "R3/R5 unexpected write", int'(a), 0);
            end else begin
                e = exp_wr.pop_front();
                check(a == e, "R3 write strobe", int'(a), int'(e));
            end
            check(sda_oe && !scl_m, "R6 strobe with ack, SCL low", int'({sda_oe, scl_m}), 2);
        end
    end

    function automatic void hist_push(input logic [7:0] v);
        for (int j = 0; j < 5; j++) hist[j] = hist[j+1];
        hist[5] = v;
    endfunction

    task automatic send_bit(input logic b, output logic s);
        sda_m = b;
        waitq();
        scl_m = 1'b1;
        repeat (Q/2) @(negedge clk);
        if (glitch_en) begin
            scl_m = 1'b0;
            @(negedge clk);
            scl_m = 1'b1;
            if (b) begin
                sda_m = 1'b0;
                @(negedge clk);
                sda_m = 1'b1;
            end
        end
        repeat (Q/2) @(negedge clk);
        s = sda_line;
        waitq();
        scl_m = 1'b0;
        waitq();
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b0; waitq();
        scl_m = 1'b0; waitq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b1; waitq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) send_bit(b[i], s);
        send_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b1, s);
            b[i] = s;
        end
        send_bit(~mack, s);
    endtask

    task automatic wr_txn(input logic [7:0] ab, input logic [7:0] sub,
                          input logic [7:0] d[$], input string req);
        logic a, e, ok, blk;
        int left, idx;
        bus_start();
        ok = (ab[7:1] == {6'b011010, addr_sel}) && !ab[0];
        send_byte(ab, a);
        check(a == ok, "R1 address ack", a, ok);
        send_byte(sub, a);
        check(a == ok, "R3 subaddress ack", a, ok);
        if (ok) last_sub = sub;
        blk = sub[7]; left = 0; idx = 0;
        for (int i = 0; i < d.size(); i++) begin
            e = 1'b0;
            if (ok) begin
                if (blk && i == 0) begin
                    if (d[0] >= 1 && d[0] <= 32) begin e = 1'b1; left = d[0]; end
                    else ok = 1'b0;
                end else if (blk && left == 0) begin
                    ok = 1'b0;
                end else begin
                    e = 1'b1;
                    exp_wr.push_back({8'h00, 1'b0, sub[6:0], 2'b00, 6'(idx), d[i]});
                    hist_push(d[i]);
                    idx++;
                    if (blk) left--;
                end
            end
            send_byte(d[i], a);
            check(a == e, req, a, e);
        end
        bus_stop();
    endtask

    task automatic rd_body(input int n, input string req);
        logic [7:0] b, e;
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, b);
            e = (k % 7 == 0) ? last_sub : hist[(k % 7) - 1];
            check(b == e, req, b, e);
        end
        check(!sda_oe, "R8 released after master NACK", sda_oe, 0);
    endtask

    task automatic rd_txn(input logic [7:0] ab, input int n, input string req);
        logic a;
        bus_start();
        send_byte(ab, a);
        check(a == 1'b1, "R1 read address ack", a, 1);
        rd_body(n, req);
        bus_stop();
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic a, s;
        for (int j = 0; j < 6; j++) hist[j] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R11: idle outputs after reset, zero history
        check(!sda_oe && !wr_en, "R11 reset outputs quiet", {sda_oe, wr_en}, 0);
        rd_txn(8'h69, 7, "R11 readback zero after reset");

        // R1: strap-off address is ignored entirely
        wr_txn(8'h6A, 8'h07, '{8'h11, 8'h22}, "R1 no ack on mismatch");

        // R3: plain write to a multi-byte register
        wr_txn(8'h68, 8'h07, '{8'hA1, 8'hB2, 8'hC3}, "R3 plain data ack");

        // R1: strap high moves the address
        addr_sel = 1'b1;
        wr_txn(8'h68, 8'h40, '{8'h5A}, "R1 old address ignored");
        wr_txn(8'h6A, 8'h40, '{8'h3C}, "R1 new address data ack");

        // R7, R8: readback with wrap
        rd_txn(8'h6B, 9, "R7 readback order and wrap");

        // R4, R5: block write of 4 with one overrun byte
        wr_txn(8'h6A, 8'h81, '{8'h04, 8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hEE}, "R4/R5 block ack");
        rd_txn(8'h6B, 7, "R7 readback after block");

        // R5: bad lengths
        wr_txn(8'h6A, 8'h88, '{8'h00, 8'h77}, "R5 zero length nacked");
        wr_txn(8'h6A, 8'h88, '{8'h21, 8'h77}, "R5 oversized length nacked");
        wr_txn(8'h6A, 8'h88, '{8'h20, 8'h99}, "R4 max length accepted");

        // R9: Stop inside a data byte
        bus_start();
        send_byte(8'h6A, a);
        send_byte(8'h01, a);
        last_sub = 8'h01;
        for (int i = 0; i < 4; i++) send_bit(1'b0, s);
        bus_stop();
        rd_txn(8'h6B, 1, "R9 partial byte dropped, subaddress kept");

        // R9: repeated Start inside a data byte, then read
        bus_start();
        send_byte(8'h6A, a);
        send_byte(8'h08, a);
        last_sub = 8'h08;
        exp_wr.push_back({8'h00, 8'h08, 2'b00, 6'd0, 8'h55});
        hist_push(8'h55);
        send_byte(8'h55, a);
        check(a == 1'b1, "R9 byte before restart acked", a, 1);
        for (int i = 0; i < 3; i++) send_bit(1'b1, s);
        bus_start();
        send_byte(8'h6B, a);
        check(a == 1'b1, "R9 repeated start begins address", a, 1);
        rd_body(7, "R9 readback after repeated start");
        bus_stop();

        // R10: one-clock glitches on both lines during a write
        glitch_en = 1'b1;
        wr_txn(8'h6A, 8'h01, '{8'hF0, 8'h0F}, "R10 data ack under glitches");
        glitch_en = 1'b0;
        rd_txn(8'h6B, 7, "R10 readback after glitched write");

        repeat (20) @(negedge clk);
        check(exp_wr.size() == 0, "R3/R4 all expected writes seen", exp_wr.size(), 0);
        finish_run();
    end
endmodule